// File: doc/BRIEF.md
# Indirect Redirection-Table Register Front End

This block is the software-visible register face of an I/O interrupt controller. Software reaches everything through three 32-bit locations decoded from an 8-bit byte offset. The first is an index register. The second is a data window that acts on whatever the index points at. The third is an end-of-interrupt port. Through the window, software can reach two identity words and a table of 64-bit redirection entries, one entry per interrupt pin. Each entry is reached as two 32-bit halves, so a full entry takes two index settings.

The front end protects two status bits in every entry from bus writes. These are the delivery-status bit and the remote-IRR bit. The delivery engine owns the remote-IRR bit and has its own port for it. After every accepted table write, the block raises a one-cycle service request. When built as version 0x20, a 4-byte write to the end-of-interrupt port is forwarded to the engine as a vector. When built as version 0x11, that port does nothing.

Top module: `irq_redir_regs`

## Requirements
- R1: Offset 0x00 holds an 8-bit index register. Writes of any size load it from wdata[7:0], and a read returns it in bits 7:0. Offsets other than 0x00, 0x10 and 0x40 read zero and change no state.
- R2: A data-window (0x10) or end-of-interrupt (0x40) access whose size is not 4 bytes (bus_size != 4) is ignored. Such a read returns zero.
- R3: Window index 0 and index 2 both read the 4-bit ID in bits 27:24, with all other bits zero. A window write at index 0 loads the ID from wdata[27:24]. Window writes at index 1 or index 2 change nothing.
- R4: Window index 1 reads the build version in bits 7:0 and NUM_PINS-1 in bits 23:16, with all other bits zero.
- R5: Entry n lives at index 0x10+2n (bits 31:0) and index 0x10+2n+1 (bits 63:32). A write replaces that half and a read returns it.
- R6: Window indices from 0x10+2*NUM_PINS upward read zero, ignore writes and raise no service request.
- R7: Bus writes never change bit 12 (delivery status) or bit 14 (remote-IRR) of an entry.
- R8: After a bus write to an entry, if its bit 15 (trigger mode, 0 = edge) is 0, its bit 14 is 0.
- R9: svc_req is high for exactly the cycle after each accepted table write, and low otherwise.
- R10: With VERSION 0x20, a 4-byte write to 0x40 makes eoi_valid high for one cycle, with eoi_vector = wdata[7:0], in the next cycle. With VERSION 0x11, eoi_valid stays low.
- R11: After reset, the index register and the ID are 0, and every entry is 0x0000_0000_0001_0000 (bit 16, mask, set).
- R12: eng_rirr_we loads eng_rirr_val into bit 14 of entry eng_rirr_idx. If a bus write hits the same entry in the same cycle, the bus data sets all other bits, bit 14 takes the engine value, and the R8 rule still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| eng_rirr_we | input | 1 | Engine remote-IRR write enable |
| eng_rirr_idx | input | IDX_W | Engine target entry |
| eng_rirr_val | input | 1 | Engine remote-IRR value |
| rte_flat | output | NUM_PINS*64 | All entries, entry n at bits 64n+63:64n |
| rirr_q | output | NUM_PINS | Remote-IRR bit of each entry |
| svc_req | output | 1 | Service request after a table write |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_vector | output | 8 | End-of-interrupt vector |

## Verification
Errors in the index register or the ID show up on the very next window read. A wrong table half-select or a wrong range decision corrupts an entry at once: rte_flat changes on the clock edge after the write, and so does the read-back. A status bit that fails to hold its value during a write, or that fails to clear on an edge entry, is visible on rirr_q one cycle after that write. A lost or spurious service request or end-of-interrupt strobe appears in the single cycle that follows the triggering write, so every check samples that exact cycle.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam logic [7:0] OFF_SEL   = 8'h00;
  localparam logic [7:0] OFF_WIN   = 8'h10;
  localparam logic [7:0] OFF_EOI   = 8'h40;
  localparam int         DSTAT_BIT = 12;
  localparam int         RIRR_BIT  = 14;
  localparam int         TRIG_BIT  = 15;
  localparam logic [63:0] RTE_RESET = 64'h0000_0000_0001_0000;

  // Merge a bus half-write into an entry, keeping protected bits.
  function automatic logic [63:0] rte_merge(input logic [63:0] old,
                                            input logic [31:0] wdata,
                                            input logic        hi,
                                            input logic        eng_we,
                                            input logic        eng_val);
    logic [63:0] n;
    n = old;
    if (hi) n[63:32] = wdata;
    else    n[31:0]  = wdata;
    n[DSTAT_BIT] = old[DSTAT_BIT];
    n[RIRR_BIT]  = eng_we ? eng_val : old[RIRR_BIT];
    if (!n[TRIG_BIT]) n[RIRR_BIT] = 1'b0;
    return n;
  endfunction

  function automatic logic [31:0] id_word(input logic [3:0] id);
    return {4'h0, id, 24'h0};
  endfunction

  function automatic logic [31:0] ver_word(input logic [7:0] ver,
                                           input logic [7:0] maxent);
    return {8'h0, maxent, 8'h0, ver};
  endfunction
endpackage

// File: rtl/irq_regs_decode.sv
module irq_regs_decode import irq_regs_pkg::*; #(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] TBL_BASE = 8'h10,
  parameter bit         EOI_EN   = 1'b1,
  localparam int        IDX_W    = $clog2(NUM_PINS)
) (
  input  logic             bus_wr,
  input  logic [7:0]       off8,
  input  logic [2:0]       bus_size,
  input  logic [7:0]       sel,
  output logic             size_ok,
  output logic             sel_wr,
  output logic             id_wr,
  output logic             tbl_wr,
  output logic             eoi_wr,
  output logic             tbl_hit,
  output logic             tbl_hi,
  output logic [IDX_W-1:0] tbl_idx
);
  localparam logic [7:0] NP8 = 8'(NUM_PINS);
  logic [7:0] rel;
  logic       win_wr;

  always_comb begin
    rel     = sel - TBL_BASE;
    tbl_hit = (sel >= TBL_BASE) && ({1'b0, rel[7:1]} < NP8);
    tbl_hi  = rel[0];
    tbl_idx = rel[IDX_W:1];
    size_ok = (bus_size == 3'd4);
    sel_wr  = bus_wr && (off8 == OFF_SEL);
    win_wr  = bus_wr && (off8 == OFF_WIN) && size_ok;
    id_wr   = win_wr && (sel == 8'd0);
    tbl_wr  = win_wr && tbl_hit;
    eoi_wr  = EOI_EN && bus_wr && (off8 == OFF_EOI) && size_ok;
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table import irq_regs_pkg::*; #(
  parameter int  NUM_PINS = 24,
  localparam int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_hi,
  input  logic [31:0]            wr_data,
  input  logic                   eng_we,
  input  logic [IDX_W-1:0]       eng_idx,
  input  logic                   eng_val,
  output logic [NUM_PINS*64-1:0] rte_flat,
  output logic [NUM_PINS-1:0]    wr_hit_vec
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic [63:0] rte;
    logic        eh;
    assign wr_hit_vec[i] = wr_en && (wr_idx == IDX_W'(i));
    assign eh            = eng_we && (eng_idx == IDX_W'(i));
    assign rte_flat[i*64 +: 64] = rte;

    always_ff @(posedge clk) begin
      if (!rst_n)             rte <= RTE_RESET;
      else if (wr_hit_vec[i]) rte <= rte_merge(rte, wr_data, wr_hi, eh, eng_val);
      else if (eh)            rte[RIRR_BIT] <= eng_val;
    end
  end
endmodule

// File: rtl/irq_regs_rdmux.sv
module irq_regs_rdmux import irq_regs_pkg::*; #(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20,
  localparam int        IDX_W    = $clog2(NUM_PINS),
  localparam logic [7:0] MAXENT  = 8'(NUM_PINS - 1)
) (
  input  logic                   bus_rd,
  input  logic [7:0]             off8,
  input  logic                   size_ok,
  input  logic [7:0]             sel,
  input  logic [3:0]             id,
  input  logic                   tbl_hit,
  input  logic                   tbl_hi,
  input  logic [IDX_W-1:0]       tbl_idx,
  input  logic [NUM_PINS*64-1:0] rte_flat,
  output logic [31:0]            rdata
);
  logic [63:0] ent;

  always_comb begin
    ent   = rte_flat[32'(tbl_idx)*64 +: 64];
    rdata = '0;
    if (bus_rd) begin
      case (off8)
        OFF_SEL: rdata = {24'h0, sel};
        OFF_WIN: if (size_ok) begin
          if (sel == 8'd0 || sel == 8'd2) rdata = id_word(id);
          else if (sel == 8'd1)           rdata = ver_word(VERSION, MAXENT);
          else if (tbl_hit)               rdata = tbl_hi ? ent[63:32] : ent[31:0];
        end
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs import irq_regs_pkg::*; #(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20,
  parameter logic [7:0] TBL_BASE = 8'h10,
  localparam int        IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [7:0]             bus_addr,
  input  logic [2:0]             bus_size,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic                   eng_rirr_we,
  input  logic [IDX_W-1:0]       eng_rirr_idx,
  input  logic                   eng_rirr_val,
  output logic [NUM_PINS*64-1:0] rte_flat,
  output logic [NUM_PINS-1:0]    rirr_q,
  output logic                   svc_req,
  output logic                   eoi_valid,
  output logic [7:0]             eoi_vector
);
  localparam bit EOI_EN = (VERSION == 8'h20);

  if (VERSION != 8'h11 && VERSION != 8'h20) begin : g_bad_version
    $error("irq_redir_regs: VERSION must be 0x11 or 0x20");
  end

  logic [7:0]          sel;
  logic [3:0]          id;
  logic [7:0]          off8;
  logic                size_ok, sel_wr, id_wr, tbl_wr_evt, eoi_wr_evt;
  logic                tbl_hit, tbl_hi;
  logic [IDX_W-1:0]    tbl_idx;
  logic [NUM_PINS-1:0] wr_hit_vec, dstat_vec, trig_vec;

  assign off8 = bus_addr;

  irq_regs_decode #(.NUM_PINS(NUM_PINS), .TBL_BASE(TBL_BASE), .EOI_EN(EOI_EN)) u_dec (
    .bus_wr(bus_wr), .off8(off8), .bus_size(bus_size), .sel(sel),
    .size_ok(size_ok), .sel_wr(sel_wr), .id_wr(id_wr), .tbl_wr(tbl_wr_evt),
    .eoi_wr(eoi_wr_evt), .tbl_hit(tbl_hit), .tbl_hi(tbl_hi), .tbl_idx(tbl_idx)
  );

  irq_redir_table #(.NUM_PINS(NUM_PINS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_evt), .wr_idx(tbl_idx),
    .wr_hi(tbl_hi), .wr_data(bus_wdata), .eng_we(eng_rirr_we),
    .eng_idx(eng_rirr_idx), .eng_val(eng_rirr_val),
    .rte_flat(rte_flat), .wr_hit_vec(wr_hit_vec)
  );

  irq_regs_rdmux #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_rd (
    .bus_rd(bus_rd), .off8(off8), .size_ok(size_ok), .sel(sel), .id(id),
    .tbl_hit(tbl_hit), .tbl_hi(tbl_hi), .tbl_idx(tbl_idx),
    .rte_flat(rte_flat), .rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bits
    assign rirr_q[i]    = rte_flat[i*64 + RIRR_BIT];
    assign dstat_vec[i] = rte_flat[i*64 + DSTAT_BIT];
    assign trig_vec[i]  = rte_flat[i*64 + TRIG_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel        <= '0;
      id         <= '0;
      svc_req    <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      if (sel_wr) sel <= bus_wdata[7:0];
      if (id_wr)  id  <= bus_wdata[27:24];
      svc_req   <= tbl_wr_evt;
      eoi_valid <= eoi_wr_evt;
      if (eoi_wr_evt) eoi_vector <= bus_wdata[7:0];
    end
  end
endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk #(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic [7:0]          off8,
  input logic [2:0]          bus_size,
  input logic [31:0]         bus_rdata,
  input logic                tbl_wr_evt,
  input logic                eoi_wr_evt,
  input logic [NUM_PINS-1:0] wr_hit_vec,
  input logic [NUM_PINS-1:0] dstat_vec,
  input logic [NUM_PINS-1:0] trig_vec,
  input logic [NUM_PINS-1:0] rirr_q,
  input logic                svc_req,
  input logic                eoi_valid
);
  p_narrow_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (off8 == 8'h10 || off8 == 8'h40) && bus_size != 3'd4) |-> bus_rdata == 32'h0);

  p_svc_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_evt |=> svc_req);

  p_svc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(tbl_wr_evt));

  p_eoi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(eoi_wr_evt));

  p_eoi_version_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (VERSION != 8'h20) |-> !eoi_valid);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    p_dstat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(dstat_vec[i]));

    p_edge_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit_vec[i] |=> (trig_vec[i] || !rirr_q[i]));
  end
endmodule

bind irq_redir_regs irq_regs_chk #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .off8(off8), .bus_size(bus_size),
  .bus_rdata(bus_rdata), .tbl_wr_evt(tbl_wr_evt), .eoi_wr_evt(eoi_wr_evt),
  .wr_hit_vec(wr_hit_vec), .dstat_vec(dstat_vec), .trig_vec(trig_vec),
  .rirr_q(rirr_q), .svc_req(svc_req), .eoi_valid(eoi_valid)
);

// File: tb/sim_irq_redir_regs.sv
`timescale 1ns/1ps
module sim_irq_redir_regs;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic eng_we = 1'b0, eng_val = 1'b0;
  logic [IW-1:0] eng_idx = '0;
  logic [31:0] rdata0, rdata1;
  logic [NP*64-1:0] flat0, flat1;
  logic [NP-1:0] rirr0, rirr1;
  logic svc0, svc1, eoiv0, eoiv1;
  logic [7:0] eoivec0, eoivec1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_redir_regs #(.NUM_PINS(NP), .VERSION(8'h20)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(rdata0), .eng_rirr_we(eng_we), .eng_rirr_idx(eng_idx),
    .eng_rirr_val(eng_val), .rte_flat(flat0), .rirr_q(rirr0),
    .svc_req(svc0), .eoi_valid(eoiv0), .eoi_vector(eoivec0));

  irq_redir_regs #(.NUM_PINS(NP), .VERSION(8'h11)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(rdata1), .eng_rirr_we(eng_we), .eng_rirr_idx(eng_idx),
    .eng_rirr_val(eng_val), .rte_flat(flat1), .rirr_q(rirr1),
    .svc_req(svc1), .eoi_valid(eoiv1), .eoi_vector(eoivec1));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 3'd4;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1 d = rdata0;
    bus_rd = 1'b0; bus_size = 3'd4;
  endtask

  task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, 3'd4, {24'h0, idx});
    rd(8'h10, 3'd4, d);
  endtask

  task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
    wr(8'h00, 3'd4, {24'h0, idx});
    wr(8'h10, 3'd4, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, 3'd4, d);          check("R11 index reset", d, 32'h0);
    rd_idx(8'h00, d);            check("R11 id reset", d, 32'h0);
    rd_idx(8'h10, d);            check("R11 entry0 low reset", d, 32'h0001_0000);
    rd_idx(8'h11, d);            check("R11 entry0 high reset", d, 32'h0);
    check("R11 last entry reset", flat0[(NP-1)*64 +: 32], 32'h0001_0000);
    check("R11 rirr reset", 32'(rirr0), 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd_idx(8'h01, d);            check("R4 version word v20", d, 32'h0017_0020);
    rd(8'h10, 3'd4, d);
    d = rdata1;                  check("R4 version word v11", d, 32'h0017_0011);
    wr_idx(8'h00, 32'h0A00_0000);
    check("R3 id write no service", 32'(svc0), 32'h0);
    rd(8'h10, 3'd4, d);          check("R3 id read index0", d, 32'h0A00_0000);
    rd_idx(8'h02, d);            check("R3 id read index2", d, 32'h0A00_0000);
    wr_idx(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, 3'd4, d);          check("R3 id field only", d, 32'h0F00_0000);
    wr_idx(8'h01, 32'h1234_5678);
    wr_idx(8'h02, 32'h0300_0000);
    rd_idx(8'h02, d);            check("R3 index1/2 writes ignored id", d, 32'h0F00_0000);
    rd_idx(8'h01, d);            check("R3 index1 write ignored", d, 32'h0017_0020);
  endtask

  task automatic t_offset();
    logic [31:0] d;
    wr(8'h00, 3'd1, 32'hFFFF_FF5A);
    rd(8'h00, 3'd2, d);          check("R1 index byte write/read", d, 32'h0000_005A);
    wr(8'h20, 3'd4, 32'h0000_0077);
    rd(8'h20, 3'd4, d);          check("R1 unmapped offset reads zero", d, 32'h0);
    rd(8'h00, 3'd4, d);          check("R1 unmapped write leaves index", d, 32'h0000_005A);
  endtask

  task automatic t_table();
    logic [31:0] d;
    wr_idx(8'h16, 32'h0000_A031);
    check("R9 service after low write", 32'(svc0), 32'h1);
    @(negedge clk);
    check("R9 service single cycle", 32'(svc0), 32'h0);
    wr_idx(8'h17, 32'hAB00_0000);
    check("R9 service after high write", 32'(svc0), 32'h1);
    rd_idx(8'h16, d);            check("R5 entry3 low", d, 32'h0000_A031);
    rd_idx(8'h17, d);            check("R5 entry3 high", d, 32'hAB00_0000);
    check("R5 entry3 on table port", flat0[3*64 +: 32], 32'h0000_A031);
  endtask

  task automatic eng(input int idx, input logic v);
    @(negedge clk);
    eng_we = 1'b1; eng_idx = IW'(idx); eng_val = v;
    @(negedge clk);
    eng_we = 1'b0;
  endtask

  task automatic t_protect();
    logic [31:0] d;
    eng(3, 1'b1);
    check("R12 engine sets rirr", 32'(rirr0[3]), 32'h1);
    wr_idx(8'h16, 32'h0000_D031);
    rd(8'h10, 3'd4, d);          check("R7 status bits kept level", d, 32'h0000_C031);
    wr_idx(8'h16, 32'h0000_8031);
    rd(8'h10, 3'd4, d);          check("R7 rirr not cleared by write", d, 32'h0000_C031);
    wr_idx(8'h16, 32'h0000_0031);
    rd(8'h10, 3'd4, d);          check("R8 edge write clears rirr", d, 32'h0000_0031);
    check("R8 rirr port after edge write", 32'(rirr0[3]), 32'h0);
  endtask

  task automatic t_conflict();
    logic [31:0] d;
    wr(8'h00, 3'd4, 32'h0000_001A);
    @(negedge clk);
    bus_addr = 8'h10; bus_size = 3'd4; bus_wdata = 32'h0000_8045; bus_wr = 1'b1;
    eng_we = 1'b1; eng_idx = IW'(5); eng_val = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_we = 1'b0;
    rd(8'h10, 3'd4, d);          check("R12 same-cycle engine set wins bit14", d, 32'h0000_C045);
    @(negedge clk);
    bus_wdata = 32'h0000_8046; bus_wr = 1'b1;
    eng_we = 1'b1; eng_val = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; eng_we = 1'b0;
    rd(8'h10, 3'd4, d);          check("R12 same-cycle engine clear wins bit14", d, 32'h0000_8046);
    @(negedge clk);
    bus_wdata = 32'h0000_0047; bus_wr = 1'b1;
    eng_we = 1'b1; eng_val = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_we = 1'b0;
    rd(8'h10, 3'd4, d);          check("R8 R12 edge beats engine set", d, 32'h0000_0047);
  endtask

  task automatic t_range();
    logic [31:0] d;
    wr_idx(8'h3F, 32'h5500_0000);
    rd(8'h10, 3'd4, d);          check("R5 last entry high", d, 32'h5500_0000);
    wr_idx(8'h40, 32'h1234_5678);
    check("R6 out-of-range no service", 32'(svc0), 32'h0);
    rd(8'h10, 3'd4, d);          check("R6 out-of-range reads zero", d, 32'h0);
    wr_idx(8'h41, 32'h1234_5678);
    rd_idx(8'h3F, d);            check("R6 last entry untouched", d, 32'h5500_0000);
    rd_idx(8'h3E, d);            check("R6 last entry low untouched", d, 32'h0001_0000);
  endtask

  task automatic t_size();
    logic [31:0] d;
    wr(8'h00, 3'd4, 32'h0000_0016);
    wr(8'h10, 3'd2, 32'h0000_FFFF);
    check("R2 narrow window write no service", 32'(svc0), 32'h0);
    rd(8'h10, 3'd4, d);          check("R2 narrow write ignored", d, 32'h0000_0031);
    rd(8'h10, 3'd1, d);          check("R2 narrow window read zero", d, 32'h0);
    wr(8'h40, 3'd2, 32'h0000_0044);
    check("R2 narrow eoi ignored", 32'(eoiv0), 32'h0);
  endtask

  task automatic t_eoi();
    wr(8'h40, 3'd4, 32'h0000_0133);
    check("R10 eoi strobe v20", 32'(eoiv0), 32'h1);
    check("R10 eoi vector", 32'(eoivec0), 32'h33);
    check("R10 no eoi in v11", 32'(eoiv1), 32'h0);
    @(negedge clk);
    check("R10 eoi single cycle", 32'(eoiv0), 32'h0);
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_offset();
    t_table();
    t_protect();
    t_conflict();
    t_range();
    t_size();
    t_eoi();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule